// File: doc/BRIEF.md
# I2C Configuration Register Target with Power-Good Write Lock

This block is an I2C target that gives the rest of the chip a small bank of seven 8-bit configuration registers. It runs on a fast system clock and treats SCL and SDA as slow inputs. Both lines pass through a synchronizer, and START, STOP and the clock edges are detected from the synchronized samples. SDA is open-drain. The block drives the line low only by asserting an output enable and never drives it high.

Two transactions are supported. A write carries a register pointer byte, then any number of data bytes. The pointer advances after each data byte. A read carries no pointer: it returns the register at the current pointer and advances the pointer after each byte it sends. The pointer stops advancing at the top register. Slot 3 is reserved, and slots 4 to 6 are frozen while the power-good lock input is high. The 7-bit target address is built from a fixed 4-bit prefix and a 3-bit strap input.

Top module: `i2c_cfg_target`

## Requirements
- R1: During reset, and directly after it, `sda_oe` is 0 and all register outputs are 0x00.
- R2: The target acknowledges a control byte only when it follows a START and its upper seven bits equal {4'b1010, addr_sel}. Otherwise it leaves SDA released until the next START.
- R3: In a write, a pointer byte from 0x00 to 0x06 is acknowledged. The next data byte, sent MSB first, is stored in that register and acknowledged.
- R4: Further data bytes in the same write go to the following registers. The pointer saturates at 0x06, so extra bytes overwrite register 6.
- R5: A read transaction, whose control byte LSB is 1, returns the register at the current pointer MSB first. The pointer then advances by one per byte, saturating at 0x06.
- R6: A master NACK after a read byte ends the transfer. SDA stays released for any further clocks until STOP or START.
- R7: A pointer byte of 0x07 or above gets a NACK, and the data bytes that follow leave every register unchanged.
- R8: While `pwr_lock` is high, a pointer byte of 0x04 to 0x06 gets a NACK and registers 4 to 6 keep their values. While `pwr_lock` is low, those registers can be written.
- R9: A write to slot 0x03 is acknowledged but stores nothing. A read of 0x03 returns 0x00, and its output slice is always 0x00.
- R10: If a write sequence advances into slot 4 while `pwr_lock` is high, that byte gets a NACK and is discarded. Bytes already written earlier in the transaction remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| addr_sel | input | 3 | Strap that selects the low three address bits |
| pwr_lock | input | 1 | Power-good lock; high freezes registers 4 to 6 |
| cfg_out | output | 56 | Register contents, register i in bits [8i+7:8i] |

## Verification
A table of single-register writes covers every slot: plain, reserved, locked and out of range, with and without the lock. Each write is followed by a read-back through the bus, which separates pointer acceptance, storage and read muxing. Directed sequences then probe the edges of the pointer:
- A burst that saturates at slot 6.
- A burst that walks through the reserved hole into a locked slot, which shows that the NACK lands exactly on the first locked byte.
- A multi-byte read that ends with a NACK.

A wrong address, a changed strap, and a byte clocked with no START in front tell apart address decoding and start detection.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_WAIT
    } i2c_state_e;

    // 7-bit target address: fixed prefix in the upper bits, strap below
    function automatic logic [6:0] own_address(input logic [3:0] prefix,
                                               input logic [2:0] strap);
        return {prefix, strap};
    endfunction

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_smp
);

    typedef struct packed {
        logic [STAGES:0] scl_sh;
        logic [STAGES:0] sda_sh;
    } sync_t;

    sync_t s_d, s_q;

    logic scl_cur, scl_prev, sda_cur, sda_prev;

    always_comb begin
        s_d        = s_q;
        s_d.scl_sh = {s_q.scl_sh[STAGES-1:0], scl_i};
        s_d.sda_sh = {s_q.sda_sh[STAGES-1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.scl_sh <= '1;
            s_q.sda_sh <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign scl_cur   = s_q.scl_sh[STAGES-1];
    assign scl_prev  = s_q.scl_sh[STAGES];
    assign sda_cur   = s_q.sda_sh[STAGES-1];
    assign sda_prev  = s_q.sda_sh[STAGES];

    assign scl_rise  = scl_cur & ~scl_prev;
    assign scl_fall  = ~scl_cur & scl_prev;
    assign start_det = scl_cur & scl_prev & sda_prev & ~sda_cur;
    assign stop_det  = scl_cur & scl_prev & ~sda_prev & sda_cur;
    assign sda_smp   = sda_cur;

endmodule

// File: rtl/i2c_proto_fsm.sv
module i2c_proto_fsm
    import i2c_cfg_pkg::*;
#(
    parameter int NUM_REGS   = 7,
    parameter int DW         = 8,
    parameter int LOCK_FIRST = 4,
    localparam int PW        = $clog2(NUM_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic          sda_smp,
    input  logic [6:0]    own_addr,
    input  logic          lock,
    input  logic [DW-1:0] rd_data,
    output logic [PW-1:0] ptr,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output logic          sda_oe
);

    localparam logic [PW-1:0] PTR_TOP = PW'(NUM_REGS - 1);

    typedef struct packed {
        i2c_state_e    state;
        logic [3:0]    cnt;
        logic [7:0]    shreg;
        logic [DW-1:0] txb;
        logic [PW-1:0] ptr;
        logic          rw;
        logic          mack;
        logic          oe;
    } fsm_t;

    fsm_t f_d, f_q;

    logic [PW-1:0] ptr_next;
    logic          ptr_ok;
    logic          data_ok;

    assign ptr_next = (f_q.ptr == PTR_TOP) ? f_q.ptr : f_q.ptr + 1'b1;
    // pointer byte is accepted when in range and not pointing at a frozen slot
    assign ptr_ok   = (f_q.shreg < 8'(NUM_REGS)) &&
                      !(lock && (f_q.shreg >= 8'(LOCK_FIRST)));
    assign data_ok  = !(lock && (f_q.ptr >= PW'(LOCK_FIRST)));

    always_comb begin
        f_d     = f_q;
        wr_en   = 1'b0;
        wr_data = f_q.shreg[DW-1:0];
        if (stop_det) begin
            f_d.state = ST_IDLE;
            f_d.oe    = 1'b0;
        end else if (start_det) begin
            f_d.state = ST_ADDR;
            f_d.cnt   = '0;
            f_d.oe    = 1'b0;
        end else begin
            unique case (f_q.state)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (scl_rise) begin
                        f_d.shreg = {f_q.shreg[6:0], sda_smp};
                        f_d.cnt   = f_q.cnt + 1'b1;
                    end else if (scl_fall && f_q.cnt == 4'd8) begin
                        f_d.cnt = '0;
                        if (f_q.state == ST_ADDR) begin
                            if (f_q.shreg[7:1] == own_addr) begin
                                f_d.rw    = f_q.shreg[0];
                                f_d.oe    = 1'b1;
                                f_d.state = ST_ADDR_ACK;
                            end else begin
                                f_d.state = ST_WAIT;
                            end
                        end else if (f_q.state == ST_PTR) begin
                            if (ptr_ok) begin
                                f_d.ptr   = f_q.shreg[PW-1:0];
                                f_d.oe    = 1'b1;
                                f_d.state = ST_PTR_ACK;
                            end else begin
                                f_d.state = ST_WAIT;
                            end
                        end else begin
                            if (data_ok) begin
                                wr_en     = 1'b1;
                                f_d.ptr   = ptr_next;
                                f_d.oe    = 1'b1;
                                f_d.state = ST_WDATA_ACK;
                            end else begin
                                f_d.state = ST_WAIT;
                            end
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (f_q.rw) begin
                            f_d.txb   = rd_data;
                            f_d.oe    = ~rd_data[DW-1];
                            f_d.cnt   = '0;
                            f_d.state = ST_RDATA;
                        end else begin
                            f_d.oe    = 1'b0;
                            f_d.state = ST_PTR;
                        end
                    end
                end
                ST_PTR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        f_d.oe    = 1'b0;
                        f_d.state = ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        f_d.cnt = f_q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (f_q.cnt == 4'd8) begin
                            f_d.oe    = 1'b0;
                            f_d.ptr   = ptr_next;
                            f_d.state = ST_RACK;
                        end else begin
                            f_d.txb = {f_q.txb[DW-2:0], 1'b0};
                            f_d.oe  = ~f_q.txb[DW-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        f_d.mack = ~sda_smp;
                    end else if (scl_fall) begin
                        if (f_q.mack) begin
                            f_d.txb   = rd_data;
                            f_d.oe    = ~rd_data[DW-1];
                            f_d.cnt   = '0;
                            f_d.state = ST_RDATA;
                        end else begin
                            f_d.state = ST_WAIT;
                        end
                    end
                end
                default: begin
                    f_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.state <= ST_IDLE;
            f_q.cnt   <= '0;
            f_q.shreg <= '0;
            f_q.txb   <= '0;
            f_q.ptr   <= '0;
            f_q.rw    <= 1'b0;
            f_q.mack  <= 1'b0;
            f_q.oe    <= 1'b0;
        end else begin
            f_q <= f_d;
        end
    end

    assign ptr    = f_q.ptr;
    assign sda_oe = f_q.oe;

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
    parameter int NUM_REGS   = 7,
    parameter int DW         = 8,
    parameter int RSVD_IDX   = 3,
    parameter int LOCK_FIRST = 4,
    localparam int PW        = $clog2(NUM_REGS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [PW-1:0]          idx,
    input  logic [DW-1:0]          wr_data,
    input  logic                   lock,
    output logic [DW-1:0]          rd_data,
    output logic [NUM_REGS*DW-1:0] cfg_flat
);

    logic [NUM_REGS-1:0][DW-1:0] regs_d, regs_q;
    logic [NUM_REGS-1:0]         permit;

    // per-slot write permission: reserved never, locked slots only when unlocked
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_permit
        if (i == RSVD_IDX) begin : g_rsvd
            assign permit[i] = 1'b0;
        end else if (i >= LOCK_FIRST) begin : g_locked
            assign permit[i] = ~lock;
        end else begin : g_free
            assign permit[i] = 1'b1;
        end
    end

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_en && idx == PW'(i) && permit[i]) begin
                regs_d[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd_data  = (idx < PW'(NUM_REGS)) ? regs_q[idx] : '0;
    assign cfg_flat = regs_q;

endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target #(
    parameter int         NUM_REGS    = 7,
    parameter int         DW          = 8,
    parameter int         RSVD_IDX    = 3,
    parameter int         LOCK_FIRST  = 4,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] ADDR_PREFIX = 4'hA,
    localparam int        PW          = $clog2(NUM_REGS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe,
    input  logic [2:0]             addr_sel,
    input  logic                   pwr_lock,
    output logic [NUM_REGS*DW-1:0] cfg_out
);

    logic          scl_rise, scl_fall, start_det, stop_det, sda_smp;
    logic [PW-1:0] ptr;
    logic          wr_en;
    logic [DW-1:0] wr_data, rd_data;
    logic [6:0]    own_addr;

    assign own_addr = i2c_cfg_pkg::own_address(ADDR_PREFIX, addr_sel);

    i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_smp   (sda_smp)
    );

    i2c_proto_fsm #(
        .NUM_REGS   (NUM_REGS),
        .DW         (DW),
        .LOCK_FIRST (LOCK_FIRST)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_smp   (sda_smp),
        .own_addr  (own_addr),
        .lock      (pwr_lock),
        .rd_data   (rd_data),
        .ptr       (ptr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe)
    );

    i2c_reg_bank #(
        .NUM_REGS   (NUM_REGS),
        .DW         (DW),
        .RSVD_IDX   (RSVD_IDX),
        .LOCK_FIRST (LOCK_FIRST)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .idx      (ptr),
        .wr_data  (wr_data),
        .lock     (pwr_lock),
        .rd_data  (rd_data),
        .cfg_flat (cfg_out)
    );

endmodule

// File: rtl/i2c_cfg_target_chk.sv
module i2c_cfg_target_chk #(
    parameter int NUM_REGS   = 7,
    parameter int DW         = 8,
    parameter int RSVD_IDX   = 3,
    parameter int LOCK_FIRST = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   scl_i,
    input logic                   sda_oe,
    input logic                   pwr_lock,
    input logic [NUM_REGS*DW-1:0] cfg_out
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (sda_oe == 1'b0 && cfg_out == '0));

    // R8
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_lock |=> $stable(cfg_out[NUM_REGS*DW-1:LOCK_FIRST*DW]));

    // R9
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_out[RSVD_IDX*DW +: DW] == '0);

    // R3
    oe_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    // R6
    oe_off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_i);

endmodule

bind i2c_cfg_target i2c_cfg_target_chk #(
    .NUM_REGS   (NUM_REGS),
    .DW         (DW),
    .RSVD_IDX   (RSVD_IDX),
    .LOCK_FIRST (LOCK_FIRST)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .pwr_lock (pwr_lock),
    .cfg_out  (cfg_out)
);

// File: tb/i2c_cfg_target_bench.sv
module i2c_cfg_target_bench;

    localparam int Q = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_line;
    logic        sda_oe;
    logic [2:0]  addr_sel = 3'd5;
    logic        pwr_lock = 1'b0;
    logic [55:0] cfg_out;
    logic [6:0][7:0] mdl = '0;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_cfg_target u_i2c_cfg_target (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .addr_sel (addr_sel),
        .pwr_lock (pwr_lock),
        .cfg_out  (cfg_out)
    );

    typedef struct packed {
        logic [7:0] ptr;
        logic [7:0] data;
        logic       lock;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{8'h00, 8'hA5, 1'b0}, '{8'h01, 8'h3C, 1'b1}, '{8'h02, 8'h81, 1'b0},
        '{8'h03, 8'hFF, 1'b0}, '{8'h04, 8'h5A, 1'b0}, '{8'h05, 8'hC3, 1'b1},
        '{8'h06, 8'h7E, 1'b0}, '{8'h09, 8'h11, 1'b0}, '{8'h04, 8'hEE, 1'b1}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; scl = 1'b1; wclk(Q);
        sda_m = 1'b0; wclk(Q);
        scl = 1'b0; wclk(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wclk(Q);
        scl = 1'b1; wclk(Q);
        sda_m = 1'b1; wclk(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wclk(Q);
            scl = 1'b1; wclk(Q);
            scl = 1'b0; wclk(Q);
        end
        sda_m = 1'b1; wclk(Q);
        scl = 1'b1; wclk(Q / 2);
        acked = (sda_line == 1'b0);
        wclk(Q / 2);
        scl = 1'b0; wclk(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic mack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wclk(Q);
            scl = 1'b1; wclk(Q / 2);
            b[i] = sda_line;
            wclk(Q / 2);
            scl = 1'b0;
        end
        wclk(Q);
        sda_m = ~mack; wclk(Q);
        scl = 1'b1; wclk(Q);
        scl = 1'b0; wclk(Q / 2);
        sda_m = 1'b1; wclk(Q);
    endtask

    // set pointer with a write transaction that carries no data
    task automatic set_ptr(input logic [7:0] p, output logic acked);
        logic a;
        bus_start;
        send_byte({7'h55, 1'b0}, a);
        send_byte(p, acked);
        bus_stop;
    endtask

    task automatic read_one(output logic [7:0] b);
        logic a;
        bus_start;
        send_byte({7'h55, 1'b1}, a);
        recv_byte(b, 1'b0);
        bus_stop;
    endtask

    initial begin
        logic a, a2, pok;
        logic [7:0] rb, rb2, rb3;
        wclk(5);
        // R1: state during reset
        chk("R1 reset oe", sda_oe, 0);
        chk("R1 reset regs", cfg_out, 0);
        rst_n = 1'b1;
        wclk(5);
        chk("R1 after reset regs", cfg_out, 0);

        // table of single writes with read-back (R3, R7, R8, R9)
        for (int v = 0; v < 9; v++) begin
            pwr_lock = VECS[v].lock;
            pok = (VECS[v].ptr < 8'd7) && !(VECS[v].lock && VECS[v].ptr >= 8'd4);
            bus_start;
            send_byte({7'h55, 1'b0}, a);
            chk("R2 control ack", a, 1);
            send_byte(VECS[v].ptr, a);
            chk("R3/R7/R8 pointer ack", a, pok);
            send_byte(VECS[v].data, a2);
            chk("R3/R7/R8 data ack", a2, pok);
            bus_stop;
            if (pok && VECS[v].ptr != 8'd3) mdl[VECS[v].ptr[2:0]] = VECS[v].data;
            chk("R3/R7/R8 register outputs", cfg_out, mdl);
            pwr_lock = 1'b0;
            if (VECS[v].ptr < 8'd7) begin
                set_ptr(VECS[v].ptr, a);
                read_one(rb);
                chk("R5/R9 read-back", rb, (VECS[v].ptr == 8'd3) ? 8'h00 : mdl[VECS[v].ptr[2:0]]);
            end
        end

        // R2: wrong address, then strap change, then byte without START
        bus_start;
        send_byte({7'h56, 1'b0}, a);
        chk("R2 wrong address nack", a, 0);
        send_byte(8'h00, a);
        chk("R2 silent after mismatch", a, 0);
        bus_stop;
        addr_sel = 3'd2;
        bus_start;
        send_byte({7'h52, 1'b0}, a);
        chk("R2 strap address ack", a, 1);
        bus_stop;
        bus_start;
        send_byte({7'h55, 1'b0}, a);
        chk("R2 old address nack", a, 0);
        bus_stop;
        addr_sel = 3'd5;
        send_byte({7'h55, 1'b0}, a);
        chk("R2 no START nack", a, 0);
        bus_stop;

        // R4: burst from 5 saturates at 6
        bus_start;
        send_byte({7'h55, 1'b0}, a);
        send_byte(8'h05, a);
        send_byte(8'h11, a);
        send_byte(8'h22, a2);
        send_byte(8'h33, a);
        chk("R4 burst last ack", a, 1);
        bus_stop;
        mdl[5] = 8'h11; mdl[6] = 8'h33;
        chk("R4 burst saturation", cfg_out, mdl);

        // R10: burst through reserved into locked slot
        pwr_lock = 1'b1;
        bus_start;
        send_byte({7'h55, 1'b0}, a);
        send_byte(8'h01, a);
        send_byte(8'h44, a);
        send_byte(8'h55, a);
        send_byte(8'h66, a2);
        chk("R9 reserved write ack", a2, 1);
        send_byte(8'h77, a);
        chk("R10 locked byte nack", a, 0);
        send_byte(8'h88, a);
        chk("R10 discarded after nack", a, 0);
        bus_stop;
        pwr_lock = 1'b0;
        mdl[1] = 8'h44; mdl[2] = 8'h55;
        chk("R10 earlier bytes kept", cfg_out, mdl);

        // R5: sequential read with increment
        set_ptr(8'h00, a);
        bus_start;
        send_byte({7'h55, 1'b1}, a);
        recv_byte(rb, 1'b1);
        recv_byte(rb2, 1'b1);
        recv_byte(rb3, 1'b0);
        bus_stop;
        chk("R5 read byte 0", rb, mdl[0]);
        chk("R5 read byte 1", rb2, mdl[1]);
        chk("R5 read byte 2", rb3, mdl[2]);
        read_one(rb);
        chk("R9 reserved read", rb, 8'h00);

        // R5: saturation at 6
        set_ptr(8'h06, a);
        bus_start;
        send_byte({7'h55, 1'b1}, a);
        recv_byte(rb, 1'b1);
        recv_byte(rb2, 1'b0);
        bus_stop;
        chk("R5 read saturate first", rb, mdl[6]);
        chk("R5 read saturate second", rb2, mdl[6]);

        // R6: after master NACK the line stays released
        set_ptr(8'h00, a);
        bus_start;
        send_byte({7'h55, 1'b1}, a);
        recv_byte(rb, 1'b0);
        recv_byte(rb2, 1'b0);
        bus_stop;
        chk("R6 byte before nack", rb, mdl[0]);
        chk("R6 released after nack", rb2, 8'hFF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule